// File: doc/BRIEF.md
# PLL Control and Status Bus Port

This block is a small slave on a 32-bit, byte-addressed memory-mapped bus that sits beside a PLL reconfiguration engine. It splits the bus address space into three regions. The low 256 bytes form a window that is forwarded to the reconfiguration engine's word-indexed management port. Address 0x100 holds an 8-bit control register. Address 0x110 returns a read-only status word.

The control register decides who drives the PLL side-band outputs: the PLL reset, the management reset, the image select and the reconfiguration request. When its source bit is set, the bus owns these outputs and the register bits drive them directly. When the source bit is clear, already-debounced single-cycle button pulses drive them, and the image select comes from a flag that each image-button pulse toggles. An indicator output shows which image is selected.

The status word puts each monitored flag in the least significant bit of its own hex digit, so a hex dump of the word can be read by eye.

Top module: `pll_ctl_port`

## Requirements
- R1: A bus access whose byte address is 0x000 to 0x0FF is forwarded in the same cycle. rc_wr and rc_rd follow bus_wr and bus_rd, rc_addr carries bus_addr[7:2] (so byte 0x18 reaches index 6), and rc_wdata equals bus_wdata.
- R2: For a window address, bus_rdata equals rc_rdata and bus_wait equals rc_wait in the same cycle. For any other address, bus_wait is 0.
- R3: A write to byte 0x100 stores bus_wdata[7:0] in the control register at the clock edge. A read of 0x100 returns the stored byte with bits 31:8 zero. The reset value is 0x04.
- R4: A read of byte 0x110 returns the status word. Bit 28 is pll_lock, bit 24 is rc_wait, bit 20 is mgmt_rst, bit 16 is pll_rst, and bits 12, 8, 4 and 0 are control bits 3, 2, 1 and 0. All other bits are zero.
- R5: A read of any address outside the window, 0x100 and 0x110 returns zero. Writes to 0x110 or to such unmapped addresses leave the control register unchanged.
- R6: When control bit 3 is 1 (bus mode), pll_rst follows control bit 0, mgmt_rst follows bit 1, img_sel follows bit 2 and recon_req is 0. In this mode the button inputs change neither the outputs nor the held image flag.
- R7: When control bit 3 is 0 (button mode), btn_rst drives both pll_rst and mgmt_rst in the same cycle, and btn_req drives recon_req in the same cycle.
- R8: In button mode, img_sel shows a held image flag. The flag is 1 after reset (alternate image) and inverts at each clock edge where btn_img is high in button mode.
- R9: img_led equals img_sel when LED_ACTIVE_HIGH is 1 and is its inverse when LED_ACTIVE_HIGH is 0.
- R10: rc_wr and rc_rd are never high for an address outside the window, and at most one region is decoded at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_wait | output | 1 | Stall for the current access |
| rc_addr | output | 6 | Word index into the reconfiguration port |
| rc_wr | output | 1 | Forwarded write strobe |
| rc_rd | output | 1 | Forwarded read strobe |
| rc_wdata | output | 32 | Forwarded write data |
| rc_rdata | input | 32 | Read data from the reconfiguration port |
| rc_wait | input | 1 | Stall from the reconfiguration port |
| pll_lock | input | 1 | PLL lock flag |
| btn_rst | input | 1 | Clean reset-button pulse |
| btn_req | input | 1 | Clean reconfigure-button pulse |
| btn_img | input | 1 | Clean image-toggle button pulse |
| pll_rst | output | 1 | PLL reset |
| mgmt_rst | output | 1 | Management reset to the reconfiguration engine |
| img_sel | output | 1 | Image select, 1 = alternate image |
| recon_req | output | 1 | Reconfiguration request |
| img_led | output | 1 | Image indicator |

## Verification
The bench builds the block with ADDR_W = 12 and LED_ACTIVE_HIGH = 1. With these values it can reach the whole 4 KiB byte space: the window, both local registers, and unmapped addresses both just above the registers and near the top of the space. A pseudo-random phase writes arbitrary control bytes, so the source bit flips often while button pulses arrive. This exercises the handover between the bus and the buttons in both directions, including whether the image flag is kept across bus-mode stretches.

// File: rtl/pcsp_pkg.sv
package pcsp_pkg;
  localparam int DATA_W     = 32;
  localparam int CTL_W      = 8;
  localparam int WIN_SPAN_W = 8;   // window covers 2**WIN_SPAN_W bytes
  localparam int IDX_W      = WIN_SPAN_W - 2;
  localparam int NIB_W      = 4;
  localparam int FLAG_N     = DATA_W / NIB_W;
  localparam logic [11:0] CTL_BYTE = 12'h100;
  localparam logic [11:0] STS_BYTE = 12'h110;

  // control register bit positions (decoded by the status word and the mux)
  localparam int BIT_PLL = 0;
  localparam int BIT_MGT = 1;
  localparam int BIT_IMG = 2;
  localparam int BIT_SRC = 3;

  typedef enum logic [1:0] {RG_WIN, RG_CTL, RG_STS, RG_NONE} region_e;

  typedef struct packed {
    logic       lock;
    logic       waitreq;
    logic       mgmt_rst;
    logic       pll_rst;
    logic [3:0] ctl_lo;
  } sts_flags_t;

  // each flag lands in bit 0 of its own nibble, flag i in nibble i
  function automatic logic [DATA_W-1:0] pack_status(sts_flags_t f);
    logic [FLAG_N-1:0] v;
    logic [DATA_W-1:0] w;
    v = f;
    w = '0;
    for (int i = 0; i < FLAG_N; i++) w[i*NIB_W] = v[i];
    return w;
  endfunction
endpackage

// File: rtl/pcsp_decode.sv
module pcsp_decode
  import pcsp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              win_hit,
  output logic              ctl_hit,
  output logic              sts_hit
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_BYTE);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_BYTE);

  always_comb begin
    win_hit = (addr >> WIN_SPAN_W) == '0;
    ctl_hit = (addr == CTL_A);
    sts_hit = (addr == STS_A);
    if (win_hit)      region = RG_WIN;
    else if (ctl_hit) region = RG_CTL;
    else if (sts_hit) region = RG_STS;
    else              region = RG_NONE;
  end
endmodule

// File: rtl/pcsp_ctrl.sv
module pcsp_ctrl
  import pcsp_pkg::*;
#(
  parameter bit IMG_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             btn_rst,
  input  logic             btn_req,
  input  logic             btn_img,
  output logic [CTL_W-1:0] ctl_q,
  output logic             src_bus,
  output logic             img_flip,
  output logic             pll_rst,
  output logic             mgmt_rst,
  output logic             img_sel,
  output logic             recon_req
);
  localparam logic [CTL_W-1:0] CTL_RST = CTL_W'(IMG_RST) << BIT_IMG;

  logic img_flag_q;

  assign src_bus  = ctl_q[BIT_SRC];
  assign img_flip = !src_bus && btn_img;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= CTL_RST;
      img_flag_q <= IMG_RST;
    end else begin
      if (ctl_wr)   ctl_q      <= ctl_wdata;
      if (img_flip) img_flag_q <= ~img_flag_q;
    end
  end

  always_comb begin
    if (src_bus) begin
      pll_rst   = ctl_q[BIT_PLL];
      mgmt_rst  = ctl_q[BIT_MGT];
      img_sel   = ctl_q[BIT_IMG];
      recon_req = 1'b0;
    end else begin
      pll_rst   = btn_rst;
      mgmt_rst  = btn_rst;
      img_sel   = img_flag_q;
      recon_req = btn_req;
    end
  end

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_q == $past(ctl_wdata)));  // R3
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_q));  // R5
  AST_IMG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_bus && btn_img) |=> (img_flag_q != $past(img_flag_q)));  // R8
  AST_BUS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    src_bus |=> $stable(img_flag_q));  // R6
endmodule

// File: rtl/pcsp_status.sv
module pcsp_status
  import pcsp_pkg::*;
(
  input  logic              lock,
  input  logic              waitreq,
  input  logic              mgmt_rst,
  input  logic              pll_rst,
  input  logic [3:0]        ctl_lo,
  output logic [DATA_W-1:0] word
);
  sts_flags_t f;
  always_comb begin
    f.lock     = lock;
    f.waitreq  = waitreq;
    f.mgmt_rst = mgmt_rst;
    f.pll_rst  = pll_rst;
    f.ctl_lo   = ctl_lo;
    word       = pack_status(f);
  end
endmodule

// File: rtl/pll_ctl_port.sv
module pll_ctl_port
  import pcsp_pkg::*;
#(
  parameter int ADDR_W          = 12,
  parameter bit IMG_RST_ALT     = 1'b1,
  parameter bit LED_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_wait,
  output logic [5:0]        rc_addr,
  output logic              rc_wr,
  output logic              rc_rd,
  output logic [31:0]       rc_wdata,
  input  logic [31:0]       rc_rdata,
  input  logic              rc_wait,
  input  logic              pll_lock,
  input  logic              btn_rst,
  input  logic              btn_req,
  input  logic              btn_img,
  output logic              pll_rst,
  output logic              mgmt_rst,
  output logic              img_sel,
  output logic              recon_req,
  output logic              img_led
);
  region_e          region;
  logic             win_hit, ctl_hit, sts_hit;
  logic             ctl_wr_ev;
  logic [CTL_W-1:0] ctl_q;
  logic             src_bus, img_flip;
  logic [31:0]      sts_word;

  pcsp_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .region(region),
    .win_hit(win_hit), .ctl_hit(ctl_hit), .sts_hit(sts_hit)
  );

  assign ctl_wr_ev = bus_wr && ctl_hit;

  pcsp_ctrl #(.IMG_RST(IMG_RST_ALT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr_ev), .ctl_wdata(bus_wdata[CTL_W-1:0]),
    .btn_rst(btn_rst), .btn_req(btn_req), .btn_img(btn_img),
    .ctl_q(ctl_q), .src_bus(src_bus), .img_flip(img_flip),
    .pll_rst(pll_rst), .mgmt_rst(mgmt_rst), .img_sel(img_sel),
    .recon_req(recon_req)
  );

  pcsp_status u_sts (
    .lock(pll_lock), .waitreq(rc_wait), .mgmt_rst(mgmt_rst),
    .pll_rst(pll_rst), .ctl_lo(ctl_q[3:0]), .word(sts_word)
  );

  // window pass-through: word index is the byte offset without its low two bits
  assign rc_addr  = bus_addr[WIN_SPAN_W-1:2];
  assign rc_wdata = bus_wdata;
  assign rc_wr    = bus_wr && win_hit;
  assign rc_rd    = bus_rd && win_hit;

  always_comb begin
    bus_wait = 1'b0;
    case (region)
      RG_WIN: begin
        bus_rdata = rc_rdata;
        bus_wait  = rc_wait;
      end
      RG_CTL:  bus_rdata = 32'(ctl_q);
      RG_STS:  bus_rdata = sts_word;
      default: bus_rdata = '0;
    endcase
  end

  generate
    if (LED_ACTIVE_HIGH) begin : g_led_hi
      assign img_led = img_sel;
    end else begin : g_led_lo
      assign img_led = ~img_sel;
    end
  endgenerate

  AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_hit, ctl_hit, sts_hit}));  // R10
  AST_WIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> !(rc_wr || rc_rd));  // R10
  AST_LOCAL_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> !bus_wait);  // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_NONE) |-> (bus_rdata == '0));  // R5
  AST_BTN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_bus && btn_rst) |-> (pll_rst && mgmt_rst));  // R7
  AST_FLIP_ONLY_BTN: assert property (@(posedge clk) disable iff (!rst_n)
    img_flip |-> btn_img);  // R8
endmodule

// File: tb/test_pll_ctl_port.sv
module test_pll_ctl_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wait;
  logic [5:0]  rc_addr;
  logic        rc_wr, rc_rd;
  logic [31:0] rc_wdata;
  logic [31:0] rc_rdata = '0;
  logic        rc_wait = 1'b0, pll_lock = 1'b0;
  logic        btn_rst = 1'b0, btn_req = 1'b0, btn_img = 1'b0;
  logic        pll_rst, mgmt_rst, img_sel, recon_req, img_led;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference state
  int m_ctl = 4;
  int m_img = 1;

  always #2 clk = ~clk;

  pll_ctl_port #(.ADDR_W(12), .IMG_RST_ALT(1'b1), .LED_ACTIVE_HIGH(1'b1)) i_pll_ctl_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .rc_addr(rc_addr), .rc_wr(rc_wr), .rc_rd(rc_rd), .rc_wdata(rc_wdata),
    .rc_rdata(rc_rdata), .rc_wait(rc_wait), .pll_lock(pll_lock),
    .btn_rst(btn_rst), .btn_req(btn_req), .btn_img(btn_img),
    .pll_rst(pll_rst), .mgmt_rst(mgmt_rst), .img_sel(img_sel),
    .recon_req(recon_req), .img_led(img_led)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference state update, behavioural
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 4;
      m_img = 1;
    end else begin
      int old;
      old = m_ctl;
      if (((old >> 3) & 1) == 0 && btn_img) m_img = 1 - m_img;
      if (bus_wr && bus_addr == 12'h100) m_ctl = int'(bus_wdata & 32'hFF);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit busmode, win;
      int e_pll, e_mgt, e_img, e_req;
      logic [31:0] e_rd, sts;
      string rq;
      busmode = ((m_ctl >> 3) & 1) == 1;
      win = bus_addr < 12'h100;
      if (busmode) begin
        e_pll = m_ctl & 1; e_mgt = (m_ctl >> 1) & 1; e_img = (m_ctl >> 2) & 1; e_req = 0;
      end else begin
        e_pll = btn_rst; e_mgt = btn_rst; e_img = m_img; e_req = btn_req;
      end
      sts = (32'(pll_lock) << 28) | (32'(rc_wait) << 24) | (32'(e_mgt) << 20) | (32'(e_pll) << 16)
          | (32'((m_ctl >> 3) & 1) << 12) | (32'((m_ctl >> 2) & 1) << 8)
          | (32'((m_ctl >> 1) & 1) << 4) | 32'(m_ctl & 1);
      if (win) begin e_rd = rc_rdata; rq = "R2"; end
      else if (bus_addr == 12'h100) begin e_rd = 32'(m_ctl); rq = "R3"; end
      else if (bus_addr == 12'h110) begin e_rd = sts; rq = "R4"; end
      else begin e_rd = 0; rq = "R5"; end
      chk("R1", "rc_wr", 32'(rc_wr), 32'(win && bus_wr));
      chk("R10", "rc_rd", 32'(rc_rd), 32'(win && bus_rd));
      chk("R1", "rc_addr", 32'(rc_addr), 32'(bus_addr >> 2) & 32'h3F);
      chk("R1", "rc_wdata", rc_wdata, bus_wdata);
      chk("R2", "bus_wait", 32'(bus_wait), win ? 32'(rc_wait) : 0);
      chk(rq, "bus_rdata", bus_rdata, e_rd);
      chk(busmode ? "R6" : "R7", "pll_rst", 32'(pll_rst), 32'(e_pll));
      chk(busmode ? "R6" : "R7", "mgmt_rst", 32'(mgmt_rst), 32'(e_mgt));
      chk(busmode ? "R6" : "R7", "recon_req", 32'(recon_req), 32'(e_req));
      chk(busmode ? "R6" : "R8", "img_sel", 32'(img_sel), 32'(e_img));
      chk("R9", "img_led", 32'(img_led), 32'(e_img));
    end
  end

  task automatic step(input logic [11:0] a, input bit wr, input bit rd, input logic [31:0] d,
                      input bit b0, input bit b1, input bit b2, input bit wt,
                      input bit lk, input logic [31:0] rdat);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d;
    btn_rst = b0; btn_req = b1; btn_img = b2;
    rc_wait = wt; pll_lock = lk; rc_rdata = rdat;
  endtask

  task automatic idle();
    step(12'h300, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 60000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state, R3 and R8
    step(12'h100, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R3", "reset ctl read", bus_rdata, 32'h4);
    chk("R8", "reset img_sel", 32'(img_sel), 1);
    step(12'h110, 0, 1, 0, 0, 0, 0, 0, 1, 0);          // R4 status with lock
    step(12'h104, 0, 1, 0, 0, 0, 0, 0, 0, 0);          // R5 unmapped
    step(12'hFFC, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R1/R2 window accesses with wait
    step(12'h018, 1, 0, 32'hA5A5_0001, 0, 0, 0, 1, 0, 0);
    step(12'h018, 1, 0, 32'hA5A5_0001, 0, 0, 0, 1, 0, 0);
    step(12'h018, 1, 0, 32'hA5A5_0001, 0, 0, 0, 0, 0, 0);
    step(12'h07C, 0, 1, 0, 0, 0, 0, 0, 0, 32'hDEAD_BEEF);
    step(12'h0FF, 0, 1, 0, 0, 0, 0, 1, 0, 32'h1234_5678);
    // R7/R8 button mode
    step(12'h110, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    step(12'h110, 0, 1, 0, 0, 1, 0, 0, 0, 0);
    step(12'h110, 0, 1, 0, 0, 0, 1, 0, 0, 0);
    idle();
    @(negedge clk) chk("R8", "img after toggle", 32'(img_sel), 0);
    step(12'h300, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle();
    // R6 bus mode 0xC then buttons ignored
    step(12'h100, 1, 0, 32'h0000_000C, 0, 0, 0, 0, 0, 0);
    step(12'h100, 0, 1, 0, 1, 1, 1, 0, 0, 0);
    step(12'h110, 0, 1, 0, 0, 0, 1, 0, 1, 0);
    step(12'h100, 1, 0, 32'hFFFF_FF09, 0, 0, 0, 0, 0, 0);
    step(12'h110, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step(12'h100, 1, 0, 32'h0000_000A, 0, 0, 0, 0, 0, 0);
    step(12'h110, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R5 writes to status / unmapped ignored
    step(12'h110, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    step(12'h108, 1, 0, 32'h0000_0003, 0, 0, 0, 0, 0, 0);
    step(12'h100, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk) chk("R5", "ctl after ignored writes", bus_rdata, 32'h0A);
    // back to button mode: flag retained
    step(12'h100, 1, 0, 32'h0000_00F1, 0, 0, 0, 0, 0, 0);
    step(12'h100, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk) chk("R8", "flag kept across bus mode", 32'(img_sel), 1);
    step(12'h100, 1, 0, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
    idle();
    // pseudo-random phase
    lf = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (lf[3:1])
        3'd0, 3'd1: a = {4'h0, lf[15:8]};
        3'd2, 3'd3: a = 12'h100;
        3'd4:       a = 12'h110;
        3'd5:       a = 12'h104;
        3'd6:       a = 12'h7F0;
        default:    a = 12'h10C;
      endcase
      step(a, lf[4], lf[5], {lf[7:0], lf[31:8]}, lf[16] & lf[17], lf[18] & lf[19],
           lf[20] & lf[21], lf[22], lf[23], {lf[15:0], lf[31:16]});
    end
    idle();
    @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule